// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block runs on the 32 kHz low-speed clock and decides when the rest of the chip may leave reset. It watches three causes. The first is a power-on condition built from two supply detectors: a coarse one and a calibrated one. The second is an active-high external reset pin. The third is an expiry event from the watchdog. From these it drives three outputs:

- a system reset;
- a power-down request for the main oscillator;
- the CPU reset.

Each cause has its own release sequence. A power or pin reset passes through a long low-power hold-off with the oscillator stopped. A watchdog reset is a short pulse and keeps the oscillator running.

The block also owns the watchdog lock bit. This bit is set at power-up, which leaves watchdog resets disabled. Software may clear it, but software can never set it again. Only a power or pin reset sets it back. A three-flag cause register tells software which event produced the most recent reset.

Top module: `rstseq_top`

## Requirements
- R1: The power-on condition is the OR of `por_coarse_i` and `por_fine_i`. While either input is high, `sys_rst_o`, `osc_pd_o`, `cpu_rst_o` and `wdt_clr_o` are high at once, without waiting for a clock edge.
- R2: `xres_i` is active high and passes through SYNC_STAGES flops. From the first sample with the pin high, `sys_rst_o` first reads high at sample SYNC_STAGES+1.
- R3: While a power or pin source is active, `osc_pd_o` is high. It stays high until the hold-off ends.
- R4: After a power or pin source is released, the outputs follow four phases, counted in slow-clock samples from the release:
  - for SYNC_STAGES+1 samples, `sys_rst_o`, `osc_pd_o` and `cpu_rst_o` are high;
  - for the next HOLDOFF_CYC (default 2048) samples, only `osc_pd_o` and `cpu_rst_o` are high;
  - for 1 sample, only `cpu_rst_o` is high;
  - after that, all three are low.
- R5: A watchdog event is a rising edge on `wdt_expire_i`, seen after SYNC_STAGES sync flops. When it is accepted, `sys_rst_o` is high for exactly one sample at sample SYNC_STAGES+1. `cpu_rst_o` is high for that sample and for one more. `osc_pd_o` never rises. A level held high does not trigger again.
- R6: `wd_lock_o` is 1 after power-up. A write (`wdctl_wr_i`=1) with `wdctl_wdata_i`=0 clears it. A write of 1 has no effect. While the lock is 1, watchdog events are ignored.
- R7: A power or pin reset sets `wd_lock_o` to 1. A watchdog reset leaves it at 0.
- R8: `wdt_clr_o` is high while a power or pin source is active and during the system-reset sample after release. It is low throughout the hold-off and throughout any watchdog reset.
- R9: A watchdog event that arrives during a power or pin sequence is ignored. This holds even if the lock was cleared meanwhile: the timing and the cause do not change.
- R10: A new pin assertion at any point, including after the sequence has finished, restarts the whole R4 sequence from its first phase.
- R11: `cause_o` bit 0 marks power-on, bit 1 marks the pin, and bit 2 marks the watchdog. Exactly one bit is set. It is the cause of the latest reset, and power-on takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_lf_i | input | 1 | 32 kHz low-speed clock |
| por_coarse_i | input | 1 | Coarse supply detector, high = supply low |
| por_fine_i | input | 1 | Calibrated supply detector, high = supply low |
| xres_i | input | 1 | External reset pin, active high, asynchronous |
| wdt_expire_i | input | 1 | Watchdog expiry, rising edge = event, asynchronous |
| wdctl_wr_i | input | 1 | Software write strobe for the lock bit |
| wdctl_wdata_i | input | 1 | Value written to the lock bit (only 0 has effect) |
| sys_rst_o | output | 1 | System reset |
| osc_pd_o | output | 1 | Main oscillator power-down request |
| cpu_rst_o | output | 1 | CPU reset |
| wdt_clr_o | output | 1 | Clears the watchdog counter |
| wd_lock_o | output | 1 | Lock bit, 1 = watchdog reset disabled |
| cause_o | output | 3 | Last reset cause: [0] power-on, [1] pin, [2] watchdog |

## Verification
The bench counts every phase of the release sequence to the exact sample. A hold-off counter that is off by one would make the power-down phase one sample too long or too short. So would an extra synchronizer stage.

Pin re-assertion is swept across offsets from the first release cycle to past the end of the sequence. A design that resumed the old sequence instead of restarting it would release the CPU early.

A watchdog edge is injected during the hold-off after the lock has been cleared. A sequencer that gated on the lock alone would cut the hold-off short and report a watchdog cause.

The watchdog input is also held high for a long time after an accepted event. A level-sensitive design would retrigger. Lock writes of 1 are checked against a design that lets software re-disable the watchdog.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  typedef enum logic [2:0] {
    ST_SRC     = 3'd0,
    ST_SRC_END = 3'd1,
    ST_LOWPWR  = 3'd2,
    ST_OSC_UP  = 3'd3,
    ST_WD_RST  = 3'd4,
    ST_WD_END  = 3'd5,
    ST_RUN     = 3'd6
  } seq_st_t;

  typedef struct packed {
    logic sys;
    logic osc_pd;
    logic cpu;
    logic wd_clr;
  } seq_out_t;

  localparam int CAUSE_W = 3;
  localparam logic [CAUSE_W-1:0] CAUSE_POWER = 3'b001;
  localparam logic [CAUSE_W-1:0] CAUSE_PIN   = 3'b010;
  localparam logic [CAUSE_W-1:0] CAUSE_WDOG  = 3'b100;

  // True on the final cycle of a hold-off window of length len.
  function automatic logic holdoff_last(input int unsigned cnt, input int unsigned len);
    return (cnt + 1) == len;
  endfunction

  function automatic int unsigned holdoff_next(input int unsigned cnt);
    return cnt + 1;
  endfunction

  // Output pattern for each sequencer state.
  function automatic seq_out_t decode_outputs(input seq_st_t st);
    seq_out_t o;
    case (st)
      ST_SRC:     o = '{sys: 1'b1, osc_pd: 1'b1, cpu: 1'b1, wd_clr: 1'b1};
      ST_SRC_END: o = '{sys: 1'b1, osc_pd: 1'b1, cpu: 1'b1, wd_clr: 1'b1};
      ST_LOWPWR:  o = '{sys: 1'b0, osc_pd: 1'b1, cpu: 1'b1, wd_clr: 1'b0};
      ST_OSC_UP:  o = '{sys: 1'b0, osc_pd: 1'b0, cpu: 1'b1, wd_clr: 1'b0};
      ST_WD_RST:  o = '{sys: 1'b1, osc_pd: 1'b0, cpu: 1'b1, wd_clr: 1'b0};
      ST_WD_END:  o = '{sys: 1'b0, osc_pd: 1'b0, cpu: 1'b1, wd_clr: 1'b0};
      ST_RUN:     o = '{sys: 1'b0, osc_pd: 1'b0, cpu: 1'b0, wd_clr: 1'b0};
      default:    o = '{sys: 1'b1, osc_pd: 1'b1, cpu: 1'b1, wd_clr: 1'b1};
    endcase
    return o;
  endfunction

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) shreg <= {STAGES{RST_VAL}};
    else      shreg <= {shreg[STAGES-2:0], d};
  end

  assign q = shreg[STAGES-1];

  initial begin
    stages_min_chk: assert (STAGES >= 2);
  end
endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
  import rstseq_pkg::*;
#(
  parameter int unsigned HOLDOFF = 2048
) (
  input  logic    clk,
  input  logic    arst,
  input  logic    src_act,
  input  logic    wd_pulse,
  input  logic    wd_lock,
  output seq_st_t st,
  output logic    src_entry,
  output logic    wd_entry
);
  localparam int CNT_W = (HOLDOFF > 2) ? $clog2(HOLDOFF) : 1;

  seq_st_t           st_d;
  logic [CNT_W-1:0]  cnt, cnt_d;
  logic              ho_last;

  assign ho_last   = holdoff_last(32'(cnt), HOLDOFF);
  assign src_entry = src_act && (st != ST_SRC);
  assign wd_entry  = !src_act && (st == ST_RUN) && wd_pulse && !wd_lock;

  always_comb begin
    st_d  = st;
    cnt_d = '0;
    if (src_act) begin
      st_d = ST_SRC;
    end else begin
      case (st)
        ST_SRC:     st_d = ST_SRC_END;
        ST_SRC_END: st_d = ST_LOWPWR;
        ST_LOWPWR: begin
          if (ho_last) st_d = ST_OSC_UP;
          else         cnt_d = CNT_W'(holdoff_next(32'(cnt)));
        end
        ST_OSC_UP:  st_d = ST_RUN;
        ST_RUN:     if (wd_entry) st_d = ST_WD_RST;
        ST_WD_RST:  st_d = ST_WD_END;
        ST_WD_END:  st_d = ST_RUN;
        default:    st_d = ST_SRC;
      endcase
    end
  end

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      st  <= ST_SRC;
      cnt <= '0;
    end else begin
      st  <= st_d;
      cnt <= cnt_d;
    end
  end

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (arst)
    32'(cnt) < HOLDOFF);

  // R9
  wd_only_run_chk: assert property (@(posedge clk) disable iff (arst)
    (st == ST_LOWPWR && !src_act && !ho_last) |=> (st == ST_LOWPWR));
endmodule

// File: rtl/rstseq_wdctl.sv
module rstseq_wdctl
  import rstseq_pkg::*;
(
  input  logic               clk,
  input  logic               arst,
  input  logic               wr_en,
  input  logic               wr_val,
  input  logic               pin_seq,
  input  logic               src_entry,
  input  logic               wd_entry,
  output logic               lock_o,
  output logic [CAUSE_W-1:0] cause_o
);
  always_ff @(posedge clk or posedge arst) begin
    if (arst)                  lock_o <= 1'b1;
    else if (pin_seq)          lock_o <= 1'b1;
    else if (wr_en && !wr_val) lock_o <= 1'b0;
  end

  always_ff @(posedge clk or posedge arst) begin
    if (arst)           cause_o <= CAUSE_POWER;
    else if (src_entry) cause_o <= CAUSE_PIN;
    else if (wd_entry)  cause_o <= CAUSE_WDOG;
  end

  // R7
  lock_set_chk: assert property (@(posedge clk) disable iff (arst)
    $rose(lock_o) |-> $past(pin_seq));

  // R6
  lock_write_one_chk: assert property (@(posedge clk) disable iff (arst)
    (wr_en && wr_val && !pin_seq) |=> $stable(lock_o));

  // R11
  cause_onehot_chk: assert property (@(posedge clk) disable iff (arst)
    $countones(cause_o) == 1);
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
  import rstseq_pkg::*;
#(
  parameter int unsigned HOLDOFF_CYC = 2048,
  parameter int          SYNC_STAGES = 2
) (
  input  logic               clk_lf_i,
  input  logic               por_coarse_i,
  input  logic               por_fine_i,
  input  logic               xres_i,
  input  logic               wdt_expire_i,
  input  logic               wdctl_wr_i,
  input  logic               wdctl_wdata_i,
  output logic               sys_rst_o,
  output logic               osc_pd_o,
  output logic               cpu_rst_o,
  output logic               wdt_clr_o,
  output logic               wd_lock_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic     por_any, por_s, xres_s, wdt_s, wdt_d;
  logic     src_act, wd_pulse, src_entry, wd_entry;
  seq_st_t  st;
  seq_out_t outs;

  assign por_any = por_coarse_i | por_fine_i;

  rstseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_por_sync (
    .clk(clk_lf_i), .arst(por_any), .d(1'b0), .q(por_s));

  rstseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pin_sync (
    .clk(clk_lf_i), .arst(por_any), .d(xres_i), .q(xres_s));

  rstseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_wdt_sync (
    .clk(clk_lf_i), .arst(por_any), .d(wdt_expire_i), .q(wdt_s));

  always_ff @(posedge clk_lf_i or posedge por_any) begin
    if (por_any) wdt_d <= 1'b0;
    else         wdt_d <= wdt_s;
  end

  assign wd_pulse = wdt_s & ~wdt_d;
  assign src_act  = por_s | xres_s;

  rstseq_fsm #(.HOLDOFF(HOLDOFF_CYC)) u_fsm (
    .clk(clk_lf_i), .arst(por_any), .src_act(src_act), .wd_pulse(wd_pulse),
    .wd_lock(wd_lock_o), .st(st), .src_entry(src_entry), .wd_entry(wd_entry));

  rstseq_wdctl u_wdctl (
    .clk(clk_lf_i), .arst(por_any), .wr_en(wdctl_wr_i), .wr_val(wdctl_wdata_i),
    .pin_seq(st == ST_SRC), .src_entry(src_entry), .wd_entry(wd_entry),
    .lock_o(wd_lock_o), .cause_o(cause_o));

  assign outs      = decode_outputs(st);
  assign sys_rst_o = por_any | outs.sys;
  assign osc_pd_o  = por_any | outs.osc_pd;
  assign cpu_rst_o = por_any | outs.cpu;
  assign wdt_clr_o = por_any | outs.wd_clr;

  // R3
  src_pd_chk: assert property (@(posedge clk_lf_i) disable iff (por_any)
    src_act |=> osc_pd_o);

  // R5
  wdr_no_pd_chk: assert property (@(posedge clk_lf_i) disable iff (por_any)
    wd_entry |=> (sys_rst_o && !osc_pd_o && cpu_rst_o));

  // R5
  wdr_short_chk: assert property (@(posedge clk_lf_i) disable iff (por_any)
    (sys_rst_o && !osc_pd_o && !src_act) |=> (!sys_rst_o && cpu_rst_o));

  // R8
  wdr_no_clr_chk: assert property (@(posedge clk_lf_i) disable iff (por_any)
    (sys_rst_o && !osc_pd_o) |-> !wdt_clr_o);

  // R4
  osc_up_order_chk: assert property (@(posedge clk_lf_i) disable iff (por_any)
    $fell(osc_pd_o) |-> (cpu_rst_o && !sys_rst_o));
endmodule

// File: tb/rstseq_top_test.sv
module rstseq_top_test;
  localparam int HO   = 2048;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic por_c, por_f, xres, wdt, wr, wdata;
  logic sys, pd, cpu, clr, lock;
  logic [2:0] cause;

  int checks = 0;
  int errs   = 0;

  rstseq_top #(.HOLDOFF_CYC(HO), .SYNC_STAGES(SYNC)) uut (
    .clk_lf_i(clk), .por_coarse_i(por_c), .por_fine_i(por_f), .xres_i(xres),
    .wdt_expire_i(wdt), .wdctl_wr_i(wr), .wdctl_wdata_i(wdata),
    .sys_rst_o(sys), .osc_pd_o(pd), .cpu_rst_o(cpu), .wdt_clr_o(clr),
    .wd_lock_o(lock), .cause_o(cause));

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called right after a power/pin source is released; inj>=0 clears the
  // lock and pulses the watchdog that many samples into the hold-off.
  task automatic expect_pwr_seq(input string tag, input int inj);
    int bad;
    int bclr;
    bad = 0;
    for (int i = 0; i < SYNC + 1; i++) begin
      step();
      if (!(sys && pd && cpu)) bad++;
    end
    check({tag, " R4 reset tail"}, bad, 0);
    check({tag, " R8 clear in reset tail"}, int'(clr), 1);
    check({tag, " R7 lock set"}, int'(lock), 1);
    bad  = 0;
    bclr = 0;
    for (int i = 0; i < HO; i++) begin
      if (i == inj)     begin wr = 1'b1; wdata = 1'b0; wdt = 1'b1; end
      if (i == inj + 1) wr = 1'b0;
      if (i == inj + 3) wdt = 1'b0;
      step();
      if (sys || !pd || !cpu) bad++;
      if (clr) bclr++;
    end
    check({tag, " R4 R9 hold-off length"}, bad, 0);
    check({tag, " R8 no clear in hold-off"}, bclr, 0);
    step();
    check({tag, " R4 osc up cycle"}, int'({sys, pd, cpu}), 3'b001);
    step();
    check({tag, " R4 cpu released"}, int'({sys, pd, cpu}), 0);
  endtask

  task automatic wdr_event(input string tag, input bit fire);
    int bad;
    wdt = 1'b1;
    bad = 0;
    for (int i = 0; i < SYNC; i++) begin
      step();
      if (sys || cpu) bad++;
    end
    check({tag, " R5 sync latency"}, bad, 0);
    step();
    check({tag, " R5 R8 first cycle"}, int'({sys, pd, cpu, clr}), fire ? 4'b1010 : 0);
    step();
    check({tag, " R5 cpu tail"}, int'({sys, pd, cpu, clr}), fire ? 4'b0010 : 0);
    bad = 0;
    for (int i = 0; i < 6; i++) begin
      step();
      if (sys || cpu || pd) bad++;
    end
    check({tag, " R5 held level no retrigger"}, bad, 0);
    wdt = 1'b0;
    bad = 0;
    for (int i = 0; i < 3; i++) begin
      step();
      if (sys || cpu) bad++;
    end
    check({tag, " R5 falling edge ignored"}, bad, 0);
  endtask

  task automatic pin_assert(input string tag);
    int bad;
    xres = 1'b1;
    bad  = 0;
    for (int i = 0; i < SYNC; i++) begin
      step();
      if (sys) bad++;
    end
    check({tag, " R2 before sync"}, bad, 0);
    step();
    check({tag, " R2 asserted"}, int'({sys, pd, cpu}), 3'b111);
    step();
    xres = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

  initial begin
    int offs [10] = '{1, 2, 3, 4, 5, 1000, 2050, 2051, 2052, 2053};
    por_c = 1'b1; por_f = 1'b0; xres = 1'b0; wdt = 1'b0; wr = 1'b0; wdata = 1'b0;
    #1;
    check("R1 immediate coarse", int'({sys, pd, cpu, clr}), 4'b1111);
    step(); step(); step();
    check("R11 power cause", int'(cause), 3'b001);
    check("R6 lock after power-up", int'(lock), 1);
    por_c = 1'b0;
    expect_pwr_seq("coarse", -1);

    por_f = 1'b1;
    #1;
    check("R1 immediate fine", int'({sys, pd, cpu, clr}), 4'b1111);
    step(); step();
    por_f = 1'b0;
    expect_pwr_seq("fine", -1);
    check("R11 power cause fine", int'(cause), 3'b001);

    wr = 1'b1; wdata = 1'b1; step(); wr = 1'b0; step();
    check("R6 write one keeps lock", int'(lock), 1);
    wdr_event("locked", 1'b0);
    check("R6 locked cause kept", int'(cause), 3'b001);
    wr = 1'b1; wdata = 1'b0; step(); wr = 1'b0; step();
    check("R6 write zero clears", int'(lock), 0);
    wr = 1'b1; wdata = 1'b1; step(); wr = 1'b0; step();
    check("R6 write one cannot relock", int'(lock), 0);

    wdr_event("enabled", 1'b1);
    check("R11 watchdog cause", int'(cause), 3'b100);
    check("R7 lock stays clear", int'(lock), 0);

    pin_assert("pin");
    check("R11 pin cause", int'(cause), 3'b010);
    expect_pwr_seq("pin inj", 10);
    check("R9 cause unchanged", int'(cause), 3'b010);
    check("R9 lock cleared by write", int'(lock), 0);
    wdr_event("after inj", 1'b1);
    check("R11 watchdog cause 2", int'(cause), 3'b100);

    foreach (offs[k]) begin
      pin_assert("sweep start");
      for (int i = 0; i < offs[k]; i++) step();
      xres = 1'b1;
      for (int i = 0; i < SYNC + 2; i++) step();
      xres = 1'b0;
      expect_pwr_seq($sformatf("R10 restart@%0d", offs[k]), -1);
      check("R10 R11 restart cause", int'(cause), 3'b010);
    end

    pin_assert("pin then power");
    for (int i = 0; i < 50; i++) step();
    por_f = 1'b1;
    step(); step(); step();
    por_f = 1'b0;
    expect_pwr_seq("R10 power over pin", -1);
    check("R11 power overrides", int'(cause), 3'b001);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule